// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command state machine of a four-bank parallel flash model. It watches single-cycle bus writes, recognises the two-write unlock prefix and the command that follows it, and moves between plain array reading, identification reading, word programming, sector or whole-device erasing, a suspended erase and a fast programming mode that needs no unlock prefix. It never touches the storage itself. It issues one-cycle program and erase strobes to the storage side. It classifies every read so that the storage side knows whether to return array data, a status byte or an identification code.

Program and erase operations are modelled as fixed cycle counts. While one runs, only the bank that holds the target reports busy. Reads to the other banks return array data with no added delay. A suspended erase frees its bank, so every location except the sector being erased can be read or programmed. An acceleration input switches on the fast programming mode while it is held and raises a protection-override flag for the storage side.

Top module: `flcmd_ctrl`

## Requirements
- R1: After reset, the bank busy vector is zero, no strobe is active, and every read is classed as array data (rd_kind 0, rd_data 0x00).
- R2: The writes 0xAA at 0x555, 0x55 at 0x2AA and 0xA0 at 0x555, followed by one write at any address, pulse pg_we for one cycle with that address and data. The target bank (address bits [11:10]) is then busy for PROG_CYC cycles.
- R3: While a bank is busy, a read to it is classed as status (rd_kind 1). Bit 6 of rd_data is inverted on each successive status read, starting at 0 after reset, and all other bits are 0. Reads to non-busy banks stay array reads.
- R4: The unlock prefix followed by 0x90 at 0x555 enters identification reading. Each read is then classed rd_kind 2, with MFR_ID at even addresses and DEV_ID at odd addresses. Writing 0xF0 leaves this mode, and all other writes are ignored.
- R5: A write with the wrong address or data at any point of an unlock prefix cancels the sequence. The next write is then taken as the first write of a new sequence.
- R6: The unlock prefix followed by 0x20 at 0x555 enters fast mode (bypass_mode 1). In fast mode, 0xA0 followed by one address/data write programs, 0x90 followed by 0x00 leaves, and other writes are ignored.
- R7: A rising acc_en enters fast mode and sets prot_ovr one cycle later. While acc_en is high, the leave command has no effect. A falling acc_en leaves fast mode.
- R8: The prefix followed by 0x80, the prefix again, then 0x30 at any address erases the sector given by address bits [11:8]. Its bank is busy for ER_CYC cycles. If the last write is 0x10 at 0x555 instead, the whole device is erased and all banks are busy for CHIP_CYC cycles. er_start pulses once per erase.
- R9: During an erase, 0xB0 suspends it and clears the busy vector. Reads to the erased sector are then status reads, while all other locations, including the same bank, read as array. A full four-write program may target any other sector. A program aimed into the erased sector is dropped. 0x30 resumes the erase for its remaining cycles.
- R10: 0xF0 written in the middle of an unlock or erase-setup sequence returns to read mode, so no program follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command code |
| acc_en | input | 1 | Acceleration request |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read classification valid, one cycle after rd_en |
| rd_kind | output | 2 | 0 array, 1 status, 2 identification |
| rd_data | output | 8 | Status or identification byte (0 for array reads) |
| bank_busy | output | 2**BANK_W | Banks currently programming or erasing |
| pg_we | output | 1 | Program strobe to storage |
| pg_addr | output | ADDR_W | Program address |
| pg_data | output | 8 | Program data |
| er_start | output | 1 | Erase strobe to storage |
| er_chip | output | 1 | Current erase covers the whole device |
| er_sect | output | SECT_W | Sector of the current erase |
| prot_ovr | output | 1 | Protection override while accelerated |
| bypass_mode | output | 1 | Fast programming mode active |

## Verification
The properties assume that PROG_CYC, ER_CYC and CHIP_CYC are all at least one, so a program or erase strobe is always followed by a cycle in which its bank reports busy. They also assume that the bus presents at most one write per cycle. The stimulus issues each write as a one-cycle strobe. It waits out programs and erases before sending new commands, except for the suspend command, which is sent mid-erase on purpose. Acceleration is raised and lowered only between sequences.

// File: rtl/flcmd_pkg.sv
`timescale 1ns/1ps
package flcmd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_UL2, S_AUTO, S_PGADDR, S_PROG,
    S_ESET, S_EUL1, S_EUL2, S_ERASE, S_BEXIT
  } fst_t;

  typedef enum logic [1:0] {C_NORM, C_SUSP, C_BYP} ctx_t;

  localparam logic [1:0] K_ARRAY = 2'd0;
  localparam logic [1:0] K_STAT  = 2'd1;
  localparam logic [1:0] K_IDENT = 2'd2;

  localparam logic [7:0] CMD_UL1    = 8'hAA;
  localparam logic [7:0] CMD_UL2    = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_AUTO   = 8'h90;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_LEAVE  = 8'h00;
endpackage

// File: rtl/flcmd_timer.sv
`timescale 1ns/1ps
module flcmd_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  input  logic          run,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= len;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = run && !load && (cnt == TW'(1));
endmodule

// File: rtl/flcmd_rdroute.sv
`timescale 1ns/1ps
module flcmd_rdroute
  import flcmd_pkg::*;
#(
  parameter int         ADDR_W = 12,
  parameter int         BANK_W = 2,
  parameter int         SECT_W = 4,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              auto_on,
  input  logic              prog_on,
  input  logic [BANK_W-1:0] prog_bank,
  input  logic              erase_on,
  input  logic              susp_on,
  input  logic              er_chip,
  input  logic [SECT_W-1:0] er_sect,
  output logic              rd_valid,
  output logic [1:0]        rd_kind,
  output logic [7:0]        rd_data
);
  logic [SECT_W-1:0] a_sect;
  logic [BANK_W-1:0] a_bank, e_bank;
  logic              hit_busy, tog;
  logic              unused_rd;

  assign a_sect    = rd_addr[ADDR_W-1 -: SECT_W];
  assign a_bank    = rd_addr[ADDR_W-1 -: BANK_W];
  assign e_bank    = er_sect[SECT_W-1 -: BANK_W];
  assign unused_rd = ^rd_addr[ADDR_W-SECT_W-1:1];

  assign hit_busy = (prog_on  && a_bank == prog_bank) ||
                    (erase_on && (er_chip || a_bank == e_bank)) ||
                    (susp_on  && (er_chip || a_sect == er_sect));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_kind  <= K_ARRAY;
      rd_data  <= '0;
      tog      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_kind  <= K_ARRAY;
      rd_data  <= '0;
      if (rd_en) begin
        if (auto_on) begin
          rd_kind <= K_IDENT;
          rd_data <= rd_addr[0] ? DEV_ID : MFR_ID;
        end else if (hit_busy) begin
          rd_kind <= K_STAT;
          rd_data <= {1'b0, tog, 6'b0};
          tog     <= ~tog;
        end
      end
    end
  end
endmodule

// File: rtl/flcmd_ctrl.sv
`timescale 1ns/1ps
module flcmd_ctrl
  import flcmd_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                BANK_W   = 2,
  parameter int                SECT_W   = 4,
  parameter int                PROG_CYC = 6,
  parameter int                ER_CYC   = 20,
  parameter int                CHIP_CYC = 40,
  parameter logic [7:0]        MFR_ID   = 8'h01,
  parameter logic [7:0]        DEV_ID   = 8'h7E,
  parameter logic [ADDR_W-1:0] UL_A1    = 'h555,
  parameter logic [ADDR_W-1:0] UL_A2    = 'h2AA
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   acc_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   rd_valid,
  output logic [1:0]             rd_kind,
  output logic [7:0]             rd_data,
  output logic [(1<<BANK_W)-1:0] bank_busy,
  output logic                   pg_we,
  output logic [ADDR_W-1:0]      pg_addr,
  output logic [7:0]             pg_data,
  output logic                   er_start,
  output logic                   er_chip,
  output logic [SECT_W-1:0]      er_sect,
  output logic                   prot_ovr,
  output logic                   bypass_mode
);
  localparam int NB   = 1 << BANK_W;
  localparam int MX1  = (ER_CYC > PROG_CYC) ? ER_CYC : PROG_CYC;
  localparam int MAXC = (CHIP_CYC > MX1) ? CHIP_CYC : MX1;
  localparam int TW   = $clog2(MAXC + 1);

  fst_t              st, st_d;
  ctx_t              ctx, ctx_d;
  logic              pt_load, pt_done, et_load, et_done;
  logic [TW-1:0]     et_len;
  logic              pg_go, er_go, chip_d;
  logic [SECT_W-1:0] sect_d, wr_sect;
  logic              hit1, hit2, at1, blocked;
  logic [NB-1:0]     busy_d;

  assign wr_sect = wr_addr[ADDR_W-1 -: SECT_W];
  assign at1     = (wr_addr == UL_A1);
  assign hit1    = at1 && (wr_data == CMD_UL1);
  assign hit2    = (wr_addr == UL_A2) && (wr_data == CMD_UL2);
  assign blocked = (ctx == C_SUSP) && (er_chip || wr_sect == er_sect);

  flcmd_timer #(.TW(TW)) u_ptim (
    .clk(clk), .rst(rst), .load(pt_load), .len(TW'(PROG_CYC)),
    .run(1'b1), .done(pt_done)
  );

  flcmd_timer #(.TW(TW)) u_etim (
    .clk(clk), .rst(rst), .load(et_load), .len(et_len),
    .run(st == S_ERASE), .done(et_done)
  );

  always_comb begin
    st_d    = st;
    ctx_d   = ctx;
    pt_load = 1'b0;
    et_load = 1'b0;
    et_len  = TW'(ER_CYC);
    pg_go   = 1'b0;
    er_go   = 1'b0;
    chip_d  = er_chip;
    sect_d  = er_sect;
    if (acc_en && !prot_ovr && ctx == C_NORM)     ctx_d = C_BYP;
    else if (!acc_en && prot_ovr && ctx == C_BYP) ctx_d = C_NORM;
    case (st)
      S_PROG: if (pt_done) st_d = S_IDLE;
      S_ERASE: begin
        if (et_done) begin
          st_d  = S_IDLE;
          ctx_d = acc_en ? C_BYP : C_NORM;
        end else if (wr_en && wr_data == CMD_SUSP) begin
          st_d  = S_IDLE;
          ctx_d = C_SUSP;
        end
      end
      default: if (wr_en) begin
        case (st)
          S_IDLE: begin
            case (ctx)
              C_BYP: begin
                if (wr_data == CMD_PROG)      st_d = S_PGADDR;
                else if (wr_data == CMD_AUTO) st_d = S_BEXIT;
              end
              C_SUSP: begin
                if (hit1) st_d = S_UL1;
                else if (wr_data == CMD_SECT) begin
                  st_d  = S_ERASE;
                  ctx_d = acc_en ? C_BYP : C_NORM;
                end
              end
              default: if (hit1) st_d = S_UL1;
            endcase
          end
          S_UL1: st_d = hit2 ? S_UL2 : S_IDLE;
          S_UL2: begin
            st_d = S_IDLE;
            if (at1 && wr_data == CMD_PROG) st_d = S_PGADDR;
            else if (at1 && ctx == C_NORM) begin
              if (wr_data == CMD_ESETUP)      st_d  = S_ESET;
              else if (wr_data == CMD_AUTO)   st_d  = S_AUTO;
              else if (wr_data == CMD_BYPASS) ctx_d = C_BYP;
            end
          end
          S_AUTO: if (wr_data == CMD_RESET) st_d = S_IDLE;
          S_PGADDR: begin
            if (blocked) st_d = S_IDLE;
            else begin
              st_d    = S_PROG;
              pg_go   = 1'b1;
              pt_load = 1'b1;
            end
          end
          S_ESET: st_d = hit1 ? S_EUL1 : S_IDLE;
          S_EUL1: st_d = hit2 ? S_EUL2 : S_IDLE;
          S_EUL2: begin
            st_d = S_IDLE;
            if (wr_data == CMD_SECT) begin
              st_d    = S_ERASE;
              er_go   = 1'b1;
              et_load = 1'b1;
              chip_d  = 1'b0;
              sect_d  = wr_sect;
            end else if (at1 && wr_data == CMD_CHIP) begin
              st_d    = S_ERASE;
              er_go   = 1'b1;
              et_load = 1'b1;
              chip_d  = 1'b1;
              et_len  = TW'(CHIP_CYC);
            end
          end
          S_BEXIT: begin
            st_d = S_IDLE;
            if (wr_data == CMD_LEAVE) ctx_d = acc_en ? C_BYP : C_NORM;
          end
          default: ;
        endcase
      end
    endcase
  end

  always_comb begin
    busy_d = '0;
    if (st == S_PROG) busy_d[pg_addr[ADDR_W-1 -: BANK_W]] = 1'b1;
    if (st == S_ERASE) begin
      if (er_chip) busy_d = '1;
      else         busy_d[er_sect[SECT_W-1 -: BANK_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      ctx         <= C_NORM;
      prot_ovr    <= 1'b0;
      pg_we       <= 1'b0;
      pg_addr     <= '0;
      pg_data     <= '0;
      er_start    <= 1'b0;
      er_chip     <= 1'b0;
      er_sect     <= '0;
      bank_busy   <= '0;
      bypass_mode <= 1'b0;
    end else begin
      st          <= st_d;
      ctx         <= ctx_d;
      prot_ovr    <= acc_en;
      pg_we       <= pg_go;
      er_start    <= er_go;
      er_chip     <= chip_d;
      er_sect     <= sect_d;
      bank_busy   <= busy_d;
      bypass_mode <= (ctx == C_BYP);
      if (pg_go) begin
        pg_addr <= wr_addr;
        pg_data <= wr_data;
      end
    end
  end

  flcmd_rdroute #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SECT_W(SECT_W),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .auto_on(st == S_AUTO), .prog_on(st == S_PROG),
    .prog_bank(pg_addr[ADDR_W-1 -: BANK_W]),
    .erase_on(st == S_ERASE), .susp_on(ctx == C_SUSP),
    .er_chip(er_chip), .er_sect(er_sect),
    .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_data(rd_data)
  );
endmodule

// File: rtl/flcmd_ctrl_chk.sv
`timescale 1ns/1ps
module flcmd_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rd_valid,
  input logic [1:0]             rd_kind,
  input logic [(1<<BANK_W)-1:0] bank_busy,
  input logic                   pg_we,
  input logic [ADDR_W-1:0]      pg_addr,
  input logic                   er_start
);
  localparam int NB = 1 << BANK_W;

  // R8
  busy_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(bank_busy) <= 1) || (&bank_busy));

  // R2
  pg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pg_we |=> !pg_we);

  // R2
  pg_bank_chk: assert property (@(posedge clk) disable iff (rst)
    pg_we |=> (bank_busy == ({{(NB-1){1'b0}}, 1'b1} << pg_addr[ADDR_W-1 -: BANK_W])));

  // R8
  er_busy_chk: assert property (@(posedge clk) disable iff (rst)
    er_start |=> (bank_busy != '0));

  // R4
  ident_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_kind == 2'd2) |-> (bank_busy == '0));
endmodule

bind flcmd_ctrl flcmd_ctrl_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_kind(rd_kind),
  .bank_busy(bank_busy), .pg_we(pg_we), .pg_addr(pg_addr), .er_start(er_start)
);

// File: tb/flcmd_ctrl_bench.sv
`timescale 1ns/1ps
module flcmd_ctrl_bench;
  localparam int PC = 6, EC = 20, CC = 40;
  localparam logic [7:0] MFR = 8'h01, DEV = 8'h7E;
  localparam int M_IDLE=0, M_UL1=1, M_UL2=2, M_AUTO=3, M_PGA=4, M_PROG=5,
                 M_ESET=6, M_EU1=7, M_EU2=8, M_ERASE=9, M_BEX=10;
  localparam int CN=0, CS=1, CB=2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, wr_en = 1'b0, acc_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic rd_valid, pg_we, er_start, er_chip, prot_ovr, bypass_mode;
  logic [1:0] rd_kind;
  logic [7:0] rd_data, pg_data;
  logic [3:0] bank_busy, er_sect;
  logic [11:0] pg_addr;

  flcmd_ctrl u_flcmd_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_en(acc_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_kind(rd_kind), .rd_data(rd_data), .bank_busy(bank_busy), .pg_we(pg_we),
    .pg_addr(pg_addr), .pg_data(pg_data), .er_start(er_start), .er_chip(er_chip),
    .er_sect(er_sect), .prot_ovr(prot_ovr), .bypass_mode(bypass_mode)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state
  int m_st, m_ctx, m_pc, m_ec, m_esect, m_pbank, n_st, n_ctx;
  bit m_accq, m_tog, m_echip;
  int e_kind, e_data, e_busy, e_pga, e_pgd, e_esect;
  bit e_valid, e_pgwe, e_erst, e_echip, e_prot, e_byp;

  function automatic bit m_busy_at(input logic [11:0] a);
    int bk, sc;
    bk = int'(a) / 1024;
    sc = int'(a) / 256;
    return (m_st == M_PROG && bk == m_pbank) ||
           (m_st == M_ERASE && (m_echip || bk == m_esect / 4)) ||
           (m_ctx == CS && (m_echip || sc == m_esect));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = M_IDLE; m_ctx = CN; m_pc = 0; m_ec = 0; m_esect = 0; m_pbank = 0;
      m_accq = 0; m_tog = 0; m_echip = 0;
      e_kind = 0; e_data = 0; e_busy = 0; e_pga = 0; e_pgd = 0; e_esect = 0;
      e_valid = 0; e_pgwe = 0; e_erst = 0; e_echip = 0; e_prot = 0; e_byp = 0;
    end else begin
      e_valid = rd_en; e_kind = 0; e_data = 0;
      if (rd_en) begin
        if (m_st == M_AUTO) begin e_kind = 2; e_data = rd_addr[0] ? DEV : MFR; end
        else if (m_busy_at(rd_addr)) begin
          e_kind = 1; e_data = m_tog ? 8'h40 : 8'h00; m_tog = !m_tog;
        end
      end
      e_busy = 0;
      if (m_st == M_PROG) e_busy = 1 << m_pbank;
      if (m_st == M_ERASE) e_busy = m_echip ? 15 : (1 << (m_esect / 4));
      e_byp = (m_ctx == CB);
      e_pgwe = 0; e_erst = 0;
      n_st = m_st; n_ctx = m_ctx;
      if (acc_en && !m_accq && m_ctx == CN) n_ctx = CB;
      else if (!acc_en && m_accq && m_ctx == CB) n_ctx = CN;
      if (m_st == M_PROG) begin
        if (m_pc == 1) n_st = M_IDLE;
        m_pc = m_pc - 1;
      end else if (m_st == M_ERASE) begin
        if (m_ec == 1) begin n_st = M_IDLE; n_ctx = acc_en ? CB : CN; end
        else if (wr_en && wr_data == 8'hB0) begin n_st = M_IDLE; n_ctx = CS; end
        m_ec = m_ec - 1;
      end else if (wr_en) begin
        bit h1, h2, a1;
        a1 = (wr_addr == 12'h555);
        h1 = a1 && wr_data == 8'hAA;
        h2 = (wr_addr == 12'h2AA) && wr_data == 8'h55;
        case (m_st)
          M_IDLE:
            if (m_ctx == CB) begin
              if (wr_data == 8'hA0) n_st = M_PGA;
              else if (wr_data == 8'h90) n_st = M_BEX;
            end else if (h1) n_st = M_UL1;
            else if (m_ctx == CS && wr_data == 8'h30) begin
              n_st = M_ERASE; n_ctx = acc_en ? CB : CN;
            end
          M_UL1: n_st = h2 ? M_UL2 : M_IDLE;
          M_UL2: begin
            n_st = M_IDLE;
            if (a1 && wr_data == 8'hA0) n_st = M_PGA;
            else if (a1 && m_ctx == CN) begin
              if (wr_data == 8'h80) n_st = M_ESET;
              else if (wr_data == 8'h90) n_st = M_AUTO;
              else if (wr_data == 8'h20) n_ctx = CB;
            end
          end
          M_AUTO: if (wr_data == 8'hF0) n_st = M_IDLE;
          M_PGA: begin
            if (m_ctx == CS && (m_echip || int'(wr_addr) / 256 == m_esect)) n_st = M_IDLE;
            else begin
              n_st = M_PROG; m_pc = PC; e_pgwe = 1;
              e_pga = wr_addr; e_pgd = wr_data; m_pbank = int'(wr_addr) / 1024;
            end
          end
          M_ESET: n_st = h1 ? M_EU1 : M_IDLE;
          M_EU1: n_st = h2 ? M_EU2 : M_IDLE;
          M_EU2: begin
            n_st = M_IDLE;
            if (wr_data == 8'h30) begin
              n_st = M_ERASE; m_ec = EC; e_erst = 1; m_echip = 0;
              m_esect = int'(wr_addr) / 256;
            end else if (a1 && wr_data == 8'h10) begin
              n_st = M_ERASE; m_ec = CC; e_erst = 1; m_echip = 1;
            end
          end
          M_BEX: begin
            n_st = M_IDLE;
            if (wr_data == 8'h00) n_ctx = acc_en ? CB : CN;
          end
          default: ;
        endcase
      end
      e_echip = m_echip; e_esect = m_esect;
      e_prot = acc_en; m_accq = acc_en;
      m_st = n_st; m_ctx = n_ctx;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(cur_req, "rd_valid", rd_valid, e_valid);
      chk(cur_req, "rd_kind", rd_kind, e_kind);
      chk(cur_req, "rd_data", rd_data, e_data);
      chk(cur_req, "bank_busy", bank_busy, e_busy);
      chk(cur_req, "pg_we", pg_we, e_pgwe);
      chk(cur_req, "pg_addr", pg_addr, e_pga);
      chk(cur_req, "pg_data", pg_data, e_pgd);
      chk(cur_req, "er_start", er_start, e_erst);
      chk(cur_req, "er_chip", er_chip, e_echip);
      chk(cur_req, "er_sect", er_sect, e_esect);
      chk(cur_req, "prot_ovr", prot_ovr, e_prot);
      chk(cur_req, "bypass_mode", bypass_mode, e_byp);
    end
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  initial begin
    idle(3); rst = 0; idle(2);
    cur_req = "R1";
    chk("R1", "reset bank_busy", bank_busy, 0);
    rd(12'h123); chk("R1", "reset read kind", rd_kind, 0);
    rd(12'hF00);

    cur_req = "R2";
    unlock(); wr(12'h555, 8'hA0); wr(12'hC12, 8'h5A);
    chk("R2", "pg_we pulse", pg_we, 1);
    chk("R2", "pg_data", pg_data, 8'h5A);
    idle(1); chk("R2", "bank3 busy", bank_busy, 4'b1000);
    cur_req = "R3";
    rd(12'hC00); chk("R3", "status kind", rd_kind, 1);
    rd(12'hC40); rd(12'h010); chk("R3", "other bank array", rd_kind, 0);
    idle(PC + 2);
    chk("R2", "program done", bank_busy, 0);

    cur_req = "R4";
    unlock(); wr(12'h555, 8'h90);
    rd(12'h000); chk("R4", "manufacturer code", rd_data, MFR);
    rd(12'h001); chk("R4", "device code", rd_data, DEV);
    wr(12'h100, 8'hA0); rd(12'h002);
    wr(12'h000, 8'hF0); rd(12'h001); chk("R4", "left ident", rd_kind, 0);

    cur_req = "R5";
    wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'hA0); wr(12'h100, 8'h33);
    idle(1); chk("R5", "no program after bad addr", bank_busy, 0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h54); wr(12'h555, 8'hA0); wr(12'h104, 8'h34);
    unlock(); wr(12'h556, 8'hA0); wr(12'h108, 8'h35);
    idle(2);

    cur_req = "R10";
    unlock(); wr(12'h555, 8'hF0); wr(12'h555, 8'hA0); wr(12'h200, 8'h44);
    idle(1); chk("R10", "reset mid-sequence", bank_busy, 0);
    unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'hF0); wr(12'h000, 8'h30);
    idle(2);

    cur_req = "R6";
    unlock(); wr(12'h555, 8'h20); idle(1);
    chk("R6", "bypass on", bypass_mode, 1);
    wr(12'h000, 8'hA0); wr(12'h400, 8'h77);
    chk("R6", "two-write program", pg_we, 1);
    idle(PC + 1);
    wr(12'h000, 8'h55); wr(12'h000, 8'hA0); wr(12'h800, 8'h11); idle(PC + 1);
    wr(12'h000, 8'h90); wr(12'h000, 8'h00); idle(1);
    chk("R6", "bypass off", bypass_mode, 0);
    wr(12'h000, 8'hA0); wr(12'h401, 8'h12); idle(2);

    cur_req = "R7";
    acc_en = 1; idle(2);
    chk("R7", "prot_ovr", prot_ovr, 1);
    chk("R7", "accel bypass", bypass_mode, 1);
    wr(12'h000, 8'hA0); wr(12'h250, 8'h99); idle(PC + 1);
    wr(12'h000, 8'h90); wr(12'h000, 8'h00); idle(1);
    chk("R7", "leave ignored", bypass_mode, 1);
    wr(12'h000, 8'hA0); wr(12'h254, 8'h98); idle(PC + 1);
    acc_en = 0; idle(2);
    chk("R7", "accel released", bypass_mode, 0);
    wr(12'h000, 8'hA0); wr(12'h260, 8'h97); idle(2);

    cur_req = "R8";
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h930, 8'h30);
    chk("R8", "erase strobe", er_start, 1);
    idle(1); chk("R8", "bank2 busy", bank_busy, 4'b0100);
    rd(12'h800); rd(12'h400);
    idle(EC + 1); chk("R8", "sector erase done", bank_busy, 0);
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
    idle(1); chk("R8", "chip busy", bank_busy, 4'hF);
    rd(12'h000); rd(12'hFFF);
    idle(CC + 1); chk("R8", "chip erase done", bank_busy, 0);

    cur_req = "R9";
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h930, 8'h30);
    idle(4); wr(12'h000, 8'hB0); idle(1);
    chk("R9", "suspended free", bank_busy, 0);
    rd(12'h9F0); chk("R9", "erased sector status", rd_kind, 1);
    rd(12'hA00); chk("R9", "same bank array", rd_kind, 0);
    unlock(); wr(12'h555, 8'hA0); wr(12'hA10, 8'h66);
    chk("R9", "program in suspend", pg_we, 1);
    rd(12'hA20); rd(12'h900); idle(PC + 1);
    unlock(); wr(12'h555, 8'hA0); wr(12'h905, 8'h67); idle(1);
    chk("R9", "program into erased sector dropped", bank_busy, 0);
    wr(12'h000, 8'h30); idle(1);
    chk("R9", "resumed", bank_busy, 4'b0100);
    idle(EC + 2);
    chk("R9", "resumed erase done", bank_busy, 0);
    rd(12'h900);
    idle(3);
    finish_run();
  end
endmodule